// File: doc/BRIEF.md
# Endpoint DMA Request Port Controller

This block links one USB endpoint FIFO to an external DMA master through an asynchronous multi-word handshake. Once software issues a start command, it raises a request whenever the endpoint can move a byte. The master answers with an acknowledge and pulses a read strobe (endpoint toward the bus) or a write strobe (bus toward the endpoint). Each qualifying strobe edge moves exactly one byte. The request is given in both true and inverted polarity.

The acknowledge and the strobes come from outside the clock domain, so each passes through a two-flop synchroniser. Byte edges are taken from the synchronised strobe, and a configuration bit chooses whether the rising or the falling edge counts. Three features can shape the request. A programmable pause withdraws it after every group of four bytes. A 32-bit byte budget can end the transfer. A receive limit for the write direction drops the request a fixed margin before the FIFO fills. A stop command ends the request and has no effect on the DMA master itself. The FIFO appears only as level, full and empty inputs plus push and pop strobes.

Top module: `epdma_req_ctrl`

## Requirements
- R1: After reset, `req` is 0, `req_n` is 1, `done` is 0, `bus_oe` is 0, and neither `fifo_pop` nor `fifo_push` is asserted.
- R2: A `cfg_go` pulse starts a transfer only when `cfg_single` is 0. While `cfg_single` is 1, a go pulse leaves the block idle and `req` stays 0.
- R3: During a transfer with `cfg_dir_in`=0 (endpoint to bus), `req` is 1 while `fifo_empty` is 0 and 0 once the FIFO is empty.
- R4: During a transfer with `cfg_dir_in`=0 and the synchronised acknowledge high, `bus_oe` is 1 and `bus_out` equals `fifo_rd_data`. Each active edge of the read strobe gives one `fifo_pop`. The edge is rising when `cfg_strobe_rise`=1 and falling when it is 0.
- R5: With `cfg_dir_in`=1 and the acknowledge high, each active write-strobe edge gives one `fifo_push` with `fifo_wdata` equal to `bus_in`, and `bus_oe` stays 0.
- R6: When `cfg_latency`=N is nonzero, `req` drops after every fourth byte moved and stays low for exactly N×`LAT_UNIT_CYCLES` clock cycles. When N is 0, `req` does not drop at four-byte boundaries.
- R7: When `cfg_count_mode`=1, the byte budget is loaded from `cfg_count` at go and each byte moved lowers it by one. When it reaches zero, `req` falls, `done` becomes 1, and later strobes move no bytes.
- R8: A `cfg_stop` pulse during a transfer makes `req` 0 and `done` 1 from the next cycle. Strobes then move no bytes until the next go.
- R9: With `cfg_dir_in`=1 and `cfg_rcv_limit`=1, `req` is 1 only while `fifo_level` < `FIFO_DEPTH`−`RCV_MARGIN` (512−32 = 480 by default). With `cfg_rcv_limit`=0, `req` is 1 while `fifo_full` is 0.
- R10: `req_n` is always the complement of `req`.
- R11: Strobe edges while the acknowledge is low move no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_go | input | 1 | One-cycle start command |
| cfg_stop | input | 1 | One-cycle request cancel command |
| cfg_single | input | 1 | 1 selects single-word mode; this block then stays idle |
| cfg_dir_in | input | 1 | 1: bus to endpoint (write strobe); 0: endpoint to bus (read strobe) |
| cfg_strobe_rise | input | 1 | 1: rising strobe edge moves a byte; 0: falling edge |
| cfg_latency | input | LAT_W | Pause length in units of LAT_UNIT_CYCLES after each 4-byte group |
| cfg_count_mode | input | 1 | Enable the byte budget |
| cfg_count | input | CNT_W | Byte budget loaded at go |
| cfg_rcv_limit | input | 1 | Early request withdrawal for the bus-to-endpoint direction |
| fifo_level | input | LVL_W | Bytes held in the endpoint FIFO |
| fifo_empty | input | 1 | FIFO empty |
| fifo_full | input | 1 | FIFO full |
| fifo_rd_data | input | DATA_W | Byte at the FIFO head |
| fifo_pop | output | 1 | Remove the head byte |
| fifo_push | output | 1 | Write `fifo_wdata` into the FIFO |
| fifo_wdata | output | DATA_W | Byte taken from the bus |
| ext_ack | input | 1 | Acknowledge from the DMA master (asynchronous) |
| ext_rd | input | 1 | Read strobe (asynchronous) |
| ext_wr | input | 1 | Write strobe (asynchronous) |
| bus_in | input | DATA_W | Data bus, inbound |
| bus_out | output | DATA_W | Data bus, outbound |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| req | output | 1 | DMA request |
| req_n | output | 1 | Inverted DMA request |
| done | output | 1 | Transfer ended by the budget or by stop |

## Verification
The bench measures the length of the pause after a four-byte group in cycles. A group counter off by one, or a pause value that is not scaled, would show up as the wrong low time, and a design that paused with N=0 would show a drop where none belongs. It tests the receive limit one byte either side of the threshold, so a `<=` compare or an unsubtracted margin would keep `req` high at 480. It sends more strobes than the byte budget and after a stop, so a design that still popped would show extra bytes moved. It holds the strobe high for several cycles under falling-edge polarity, so an edge detector with the wrong polarity would pop early.

// File: rtl/epdma_pkg.sv
// Shared types for the endpoint DMA request port controller.
package epdma_pkg;
    // Transfer state: idle or running a multi-word transfer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } epdma_state_e;
endpackage

// File: rtl/epdma_sync.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherence is given.
module epdma_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/epdma_holdoff.sv
// Counts bytes in groups of GRP_BYTES. At the end of each group it
// loads a pause of latency*UNIT cycles, during which hold is 1.
// Assumes byte_ev is a one-cycle event per byte moved.
module epdma_holdoff #(
    parameter int GRP_BYTES = 4,
    parameter int LAT_W     = 4,
    parameter int UNIT      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_ev,
    input  logic [LAT_W-1:0] latency,
    output logic             hold
);
    localparam int GW = (GRP_BYTES > 1) ? $clog2(GRP_BYTES) : 1;
    localparam int HW = $clog2(((1 << LAT_W) - 1) * UNIT + 1);
    localparam logic [GW-1:0] GRP_LAST = GW'(GRP_BYTES - 1);

    logic [GW-1:0] grp_q;
    logic [HW-1:0] cnt_q;
    logic          grp_end;

    assign grp_end = byte_ev && (grp_q == GRP_LAST);

    // Position of the current byte within its group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            grp_q <= '0;
        end else if (grp_end) begin
            grp_q <= '0;
        end else if (byte_ev) begin
            grp_q <= grp_q + 1'b1;
        end
    end

    // Pause counter: loaded at a group end, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (grp_end && (latency != '0)) begin
            cnt_q <= HW'(latency) * HW'(UNIT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign hold = (cnt_q != '0);
endmodule

// File: rtl/epdma_budget.sv
// Byte budget down-counter: loaded at start, lowered once per byte.
// Assumes dec is never asserted in the same cycle as load.
module epdma_budget #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] rem_q;

    // Remaining byte count; saturates at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign zero = (rem_q == '0);
endmodule

// File: rtl/epdma_req_ctrl.sv
// Endpoint DMA request port controller (top).
// Runs the multi-word request/acknowledge/strobe handshake between an
// endpoint FIFO and an external DMA master, in either direction.
// Assumes bus_in is stable around the write strobe for at least the
// synchroniser delay, and that the FIFO pop/push act in the same cycle.
module epdma_req_ctrl #(
    parameter int DATA_W          = 8,
    parameter int LVL_W           = 10,
    parameter int FIFO_DEPTH      = 512,
    parameter int RCV_MARGIN      = 32,
    parameter int LAT_W           = 4,
    parameter int LAT_UNIT_CYCLES = 17,
    parameter int CNT_W           = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_go,
    input  logic              cfg_stop,
    input  logic              cfg_single,
    input  logic              cfg_dir_in,
    input  logic              cfg_strobe_rise,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              cfg_count_mode,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_rcv_limit,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    input  logic              ext_ack,
    input  logic              ext_rd,
    input  logic              ext_wr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              req,
    output logic              req_n,
    output logic              done
);
    import epdma_pkg::*;

    localparam logic [LVL_W-1:0] LIMIT_LVL = LVL_W'(FIFO_DEPTH - RCV_MARGIN);

    epdma_state_e state_q;
    logic         active;
    logic         go_ok;
    logic [2:0]   hs_sync;
    logic         ack_s, rd_s, wr_s;
    logic         strb_sel, strb_q, strb_edge;
    logic         xfer, byte_ev, hold, budget_zero, budget_out;
    logic         room;

    assign active = (state_q == ST_RUN);
    assign go_ok  = cfg_go && !cfg_single;

    epdma_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_ack, ext_rd, ext_wr}),
        .d_sync  (hs_sync)
    );
    assign {ack_s, rd_s, wr_s} = hs_sync;

    // Previous value of the strobe for the selected direction.
    assign strb_sel = cfg_dir_in ? wr_s : rd_s;
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb_sel;
    end

    assign strb_edge  = cfg_strobe_rise ? (strb_sel && !strb_q)
                                        : (!strb_sel && strb_q);
    assign budget_out = cfg_count_mode && budget_zero;
    assign xfer       = active && ack_s && strb_edge && !budget_out;
    assign fifo_pop   = xfer && !cfg_dir_in && !fifo_empty;
    assign fifo_push  = xfer && cfg_dir_in && !fifo_full;
    assign byte_ev    = fifo_pop || fifo_push;
    assign fifo_wdata = bus_in;
    assign bus_out    = fifo_rd_data;
    assign bus_oe     = active && !cfg_dir_in && ack_s;

    epdma_holdoff #(
        .GRP_BYTES (4),
        .LAT_W     (LAT_W),
        .UNIT      (LAT_UNIT_CYCLES)
    ) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go_ok),
        .byte_ev (byte_ev),
        .latency (cfg_latency),
        .hold    (hold)
    );

    epdma_budget #(.CNT_W(CNT_W)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_ok),
        .load_val (cfg_count),
        .dec      (byte_ev && cfg_count_mode),
        .zero     (budget_zero)
    );

    // Whether the endpoint can take or give a byte in this direction.
    always_comb begin
        if (cfg_dir_in) begin
            room = cfg_rcv_limit ? (fifo_level < LIMIT_LVL) : !fifo_full;
        end else begin
            room = !fifo_empty;
        end
    end

    assign req   = active && !hold && room && !budget_out;
    assign req_n = !req;

    // Transfer state and done flag: go starts, stop or spent budget ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else if (go_ok) begin
            state_q <= ST_RUN;
            done    <= 1'b0;
        end else if (active && (cfg_stop || budget_out)) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
        end
    end
endmodule

// File: rtl/epdma_req_ctrl_chk.sv
// Assertion checker for epdma_req_ctrl, attached with bind below.
module epdma_req_ctrl_chk #(
    parameter int LVL_W = 10,
    parameter int LIMIT = 480
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             hold,
    input logic             cfg_go,
    input logic             cfg_stop,
    input logic             cfg_single,
    input logic             cfg_dir_in,
    input logic             cfg_rcv_limit,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_pop,
    input logic             fifo_push,
    input logic             bus_oe,
    input logic             req,
    input logic             done
);
    assert_single_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && cfg_single) |=> !active);

    assert_oe_out_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !cfg_dir_in);

    assert_one_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop && fifo_push));

    assert_pause_masks_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !req);

    assert_done_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> done);

    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cfg_stop && !(cfg_go && !cfg_single)) |=> (!req && done));

    assert_rcv_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cfg_dir_in && cfg_rcv_limit) |-> (fifo_level < LVL_W'(LIMIT)));
endmodule

bind epdma_req_ctrl epdma_req_ctrl_chk #(
    .LVL_W (LVL_W),
    .LIMIT (FIFO_DEPTH - RCV_MARGIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .hold          (hold),
    .cfg_go        (cfg_go),
    .cfg_stop      (cfg_stop),
    .cfg_single    (cfg_single),
    .cfg_dir_in    (cfg_dir_in),
    .cfg_rcv_limit (cfg_rcv_limit),
    .fifo_level    (fifo_level),
    .fifo_pop      (fifo_pop),
    .fifo_push     (fifo_push),
    .bus_oe        (bus_oe),
    .req           (req),
    .done          (done)
);

// File: tb/epdma_req_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for epdma_req_ctrl with a behavioural FIFO level model.
module epdma_req_ctrl_bench;
    localparam int UNIT = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_go = 0, cfg_stop = 0, cfg_single = 0, cfg_dir_in = 0;
    logic        cfg_strobe_rise = 1, cfg_count_mode = 0, cfg_rcv_limit = 0;
    logic [3:0]  cfg_latency = 0;
    logic [31:0] cfg_count = 0;
    logic        ext_ack = 0, ext_rd = 0, ext_wr = 0;
    logic [7:0]  bus_in = 0;
    logic        fifo_pop, fifo_push, bus_oe, req, req_n, done;
    logic [7:0]  fifo_wdata, bus_out, fifo_rd_data;
    logic [9:0]  fifo_level;

    int level = 0;
    int pops = 0, pushes = 0;
    logic [7:0] last_w = 0;
    int low_run = 0, last_run = 0;
    bit saw_low = 0;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    assign fifo_level   = level[9:0];
    assign fifo_rd_data = 8'h40 + pops[7:0];

    epdma_req_ctrl u_epdma_req_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_go(cfg_go), .cfg_stop(cfg_stop),
        .cfg_single(cfg_single), .cfg_dir_in(cfg_dir_in),
        .cfg_strobe_rise(cfg_strobe_rise), .cfg_latency(cfg_latency),
        .cfg_count_mode(cfg_count_mode), .cfg_count(cfg_count),
        .cfg_rcv_limit(cfg_rcv_limit), .fifo_level(fifo_level),
        .fifo_empty(level == 0), .fifo_full(level >= 512),
        .fifo_rd_data(fifo_rd_data), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .ext_ack(ext_ack), .ext_rd(ext_rd),
        .ext_wr(ext_wr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .req(req), .req_n(req_n), .done(done)
    );

    // FIFO model: level follows pops and pushes.
    always @(posedge clk) begin
        if (fifo_pop)  begin level <= level - 1; pops <= pops + 1; end
        if (fifo_push) begin level <= level + 1; pushes <= pushes + 1; last_w <= fifo_wdata; end
    end

    // Length of the most recent run of low request cycles.
    always @(negedge clk) begin
        if (!req) begin
            low_run <= low_run + 1;
            saw_low <= 1'b1;
        end else begin
            if (low_run > 0) last_run <= low_run;
            low_run <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic go();
        @(negedge clk) cfg_go = 1;
        @(negedge clk) cfg_go = 0;
    endtask

    task automatic strobe();
        if (cfg_dir_in) ext_wr = 1; else ext_rd = 1;
        repeat (5) @(negedge clk);
        if (cfg_dir_in) ext_wr = 0; else ext_rd = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic setup(input bit dir, input int lvl);
        @(negedge clk);
        cfg_dir_in = dir; cfg_strobe_rise = 1; cfg_latency = 0;
        cfg_count_mode = 0; cfg_rcv_limit = 0; cfg_single = 0;
        level = lvl; ext_ack = 0; ext_rd = 0; ext_wr = 0;
        cfg_stop = 1;
        @(negedge clk) cfg_stop = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(req == 0, "R1 req", req, 0);
        check(req_n == 1, "R10 req_n", req_n, 1);
        check(done == 0 && bus_oe == 0, "R1 done/oe", {done, bus_oe}, 0);
        check(!fifo_pop && !fifo_push, "R1 pop/push", {fifo_pop, fifo_push}, 0);
    endtask

    task automatic t_single();
        setup(0, 10);
        cfg_single = 1;
        go();
        repeat (2) @(negedge clk);
        check(req == 0, "R2 single blocks go", req, 0);
        cfg_single = 0;
        go();
        check(req == 1, "R2 go starts", req, 1);
        check(req_n == 0, "R10 req_n in run", req_n, 0);
    endtask

    task automatic t_out_basic();
        int p0;
        setup(0, 6);
        go();
        check(req == 1, "R3 req with data", req, 1);
        ext_ack = 1;
        repeat (3) @(negedge clk);
        check(bus_oe == 1 && bus_out == fifo_rd_data, "R4 bus drive", bus_out, fifo_rd_data);
        saw_low = 0;
        p0 = pops;
        for (int i = 0; i < 5; i++) strobe();
        check(pops - p0 == 5, "R4 pops per rising edge", pops - p0, 5);
        check(saw_low == 0 && req == 1, "R6 no pause when N=0", saw_low, 0);
        ext_ack = 0;
        repeat (3) @(negedge clk);
        p0 = pops;
        strobe();
        check(pops == p0, "R11 strobe without ack", pops - p0, 0);
        check(bus_oe == 0, "R4 no drive without ack", bus_oe, 0);
        ext_ack = 1;
        repeat (3) @(negedge clk);
        strobe();
        check(level == 0 && req == 0, "R3 req low when empty", req, 0);
    endtask

    task automatic t_polarity();
        int p0;
        setup(0, 5);
        cfg_strobe_rise = 0;
        go();
        ext_ack = 1;
        repeat (3) @(negedge clk);
        p0 = pops;
        ext_rd = 1;
        repeat (5) @(negedge clk);
        check(pops == p0, "R4 falling mode ignores rise", pops - p0, 0);
        ext_rd = 0;
        repeat (5) @(negedge clk);
        check(pops - p0 == 1, "R4 falling mode pops on fall", pops - p0, 1);
    endtask

    task automatic t_in();
        int q0;
        setup(1, 100);
        go();
        ext_ack = 1;
        bus_in = 8'h5A;
        repeat (3) @(negedge clk);
        q0 = pushes;
        strobe();
        check(pushes - q0 == 1 && level == 101, "R5 one push", pushes - q0, 1);
        check(last_w == 8'h5A, "R5 push data", last_w, 8'h5A);
        check(bus_oe == 0, "R5 no drive when in", bus_oe, 0);
    endtask

    task automatic t_rcv_limit();
        setup(1, 479);
        cfg_rcv_limit = 1;
        go();
        check(req == 1, "R9 below limit", req, 1);
        level = 480;
        @(negedge clk);
        check(req == 0, "R9 at limit", req, 0);
        cfg_rcv_limit = 0;
        level = 511;
        @(negedge clk);
        check(req == 1, "R9 no limit not full", req, 1);
        level = 512;
        @(negedge clk);
        check(req == 0, "R9 no limit full", req, 0);
    endtask

    task automatic t_latency();
        setup(0, 20);
        cfg_latency = 3;
        go();
        ext_ack = 1;
        repeat (3) @(negedge clk);
        last_run = 0;
        for (int i = 0; i < 4; i++) strobe();
        for (int i = 0; i < 200 && req == 0; i++) @(negedge clk);
        @(negedge clk);
        check(last_run == 3 * UNIT, "R6 pause length", last_run, 3 * UNIT);
    endtask

    task automatic t_count();
        int p0;
        setup(0, 20);
        cfg_count_mode = 1;
        cfg_count = 5;
        go();
        ext_ack = 1;
        repeat (3) @(negedge clk);
        p0 = pops;
        for (int i = 0; i < 7; i++) strobe();
        check(pops - p0 == 5, "R7 budget bytes", pops - p0, 5);
        check(done == 1 && req == 0, "R7 done at zero", {done, req}, 2);
    endtask

    task automatic t_stop();
        int p0;
        setup(0, 20);
        go();
        ext_ack = 1;
        repeat (3) @(negedge clk);
        strobe();
        @(negedge clk) cfg_stop = 1;
        @(negedge clk) cfg_stop = 0;
        check(req == 0 && done == 1, "R8 stop", {req, done}, 1);
        p0 = pops;
        strobe();
        strobe();
        check(pops == p0, "R8 no bytes after stop", pops - p0, 0);
        go();
        check(req == 1 && done == 0, "R8 go restarts", {req, done}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_single();
        t_out_basic();
        t_polarity();
        t_in();
        t_rcv_limit();
        t_latency();
        t_count();
        t_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule